// File: doc/BRIEF.md
# Double-Buffered Tile Routing Configuration Store

This block holds the routing select registers of one tile in two full copies, a primary copy and a shadow copy. A level-sensitive bank-steer input decides which copy a configuration write lands in. A second level-sensitive input, the live-swap input, decides which copy drives the routing. Software can therefore load a complete new route into the shadow copy while the primary route keeps carrying traffic, and then switch every select at once by raising a single control line.

Configuration accesses use one flat address made of three fields. The lowest field must match the tile's own identifier. The middle field must match the feature number given to this block as a parameter. The top field picks a select register. Read-back returns the addressed register from the copy chosen by the bank-steer input, one cycle after the read request. Select register 0 drives an example output multiplexer that picks one of several input lanes. Selects that point past the last lane give an all-zero output.

Top module: `dbcfg_tile`

## Requirements
- R1: While `rst` is high at a clock edge, every register in both copies and `rdata` become 0. After reset, `route_out` equals lane 0 with either value of `shadow_live`.
- R2: A write with `cfg_write` high, `shadow_sel` low and an accepted address stores `cfg_wdata[7:0]` into the addressed primary register. The new value is visible from the next cycle. The shadow copy does not change.
- R3: A write with `shadow_sel` high and an accepted address stores `cfg_wdata[7:0]` into the addressed shadow register only. The primary copy keeps its value.
- R4: While `shadow_live` is low, `route_out` follows primary register 0, even after that register's shadow copy has been rewritten.
- R5: While `shadow_live` is high, `route_out` follows shadow register 0. Changing `shadow_live` affects `route_out` in the same cycle, with no clock edge needed.
- R6: A read (`cfg_read` high) whose tile and feature fields match loads `rdata` at the next edge with the addressed register, zero-extended, from the copy selected by `shadow_sel`. Any other cycle leaves `rdata` unchanged, including a read addressed to another tile.
- R7: A write whose tile field `cfg_addr[15:0]` differs from `tile_id` changes neither copy.
- R8: A write whose feature field `cfg_addr[23:16]` differs from the FEATURE_ID parameter (default 5) is ignored. A write whose register field `cfg_addr[31:24]` is NUM_REGS (default 4) or higher is ignored, and a read of such a register returns 0.
- R9: A select value at or above NUM_IN (default 4) makes `route_out` 0. Otherwise `route_out` is lane `sel`, taken from `route_in[sel*16 +: 16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_id | input | 16 | Identifier of this tile, compared with the address tile field |
| cfg_addr | input | 32 | Configuration address: register[31:24], feature[23:16], tile[15:0] |
| cfg_wdata | input | 32 | Write data; the low 8 bits are stored |
| cfg_write | input | 1 | Write strobe |
| cfg_read | input | 1 | Read strobe |
| shadow_sel | input | 1 | Level: 0 steers accesses to the primary copy, 1 to the shadow copy |
| shadow_live | input | 1 | Level: 0 routes from the primary copy, 1 from the shadow copy |
| rdata | output | 32 | Registered read-back data |
| route_in | input | 64 | Four 16-bit input lanes, lane i at bits [16i+15:16i] |
| route_out | output | 16 | Output of the example routing multiplexer |

## Verification
Writes take one edge to land, so the bench checks their effect by a read in a later cycle. Reads are due at the first falling edge after the edge that captured the request, and the bench samples `rdata` at that falling edge. `route_out` is combinational from the live-swap input and the stored selects. The bench checks it 1 ns after changing `shadow_live` in the low clock phase, with no edge in between, which shows the swap needs no clock. Every ignored write is followed by a read of the same register through the normal read port.

// File: rtl/dbcfg_pkg.sv
package dbcfg_pkg;

  typedef enum logic {
    BANK_PRIMARY = 1'b0,
    BANK_SHADOW  = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;

  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbcfg_addr_decode.sv
module dbcfg_addr_decode #(
  parameter int ADDR_W     = 32,
  parameter int TILE_W     = 16,
  parameter int FEAT_W     = 8,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 4,
  parameter int FEATURE_ID = 5,
  localparam int IDX_W     = dbcfg_pkg::idx_width(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TILE_W-1:0] tile_id,
  output logic              sel_hit,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx
);

  localparam int FEAT_LSB = TILE_W;
  localparam int REG_LSB  = TILE_W + FEAT_W;

  logic [TILE_W-1:0] tile_f;
  logic [FEAT_W-1:0] feat_f;
  logic [REG_W-1:0]  reg_f;

  assign tile_f = addr[TILE_W-1:0];
  assign feat_f = addr[FEAT_LSB +: FEAT_W];
  assign reg_f  = addr[REG_LSB +: REG_W];

  // Tile and feature fields must both match for any access.
  assign sel_hit  = (tile_f == tile_id) && (feat_f == FEAT_W'(FEATURE_ID));
  assign in_range = ({1'b0, reg_f} < (REG_W+1)'(NUM_REGS));
  assign idx      = reg_f[IDX_W-1:0];

endmodule

// File: rtl/dbcfg_bank.sv
module dbcfg_bank #(
  parameter int NUM_REGS = 4,
  parameter int VAL_W    = 8,
  localparam int IDX_W   = dbcfg_pkg::idx_width(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VAL_W-1:0] wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [VAL_W-1:0] rval,
  output logic [VAL_W-1:0] sel0
);

  logic [VAL_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[widx] <= wval;
    end
  end

  assign rval = regs_q[ridx];
  assign sel0 = regs_q[0];

endmodule

// File: rtl/dbcfg_route_mux.sv
module dbcfg_route_mux #(
  parameter int NUM_IN = 4,
  parameter int LANE_W = 16,
  parameter int SEL_W  = 8
) (
  input  logic [NUM_IN*LANE_W-1:0] lanes,
  input  logic [SEL_W-1:0]         sel,
  output logic [LANE_W-1:0]        out
);

  // Selects past the last lane give zero.
  always_comb begin
    out = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel == SEL_W'(i)) out = lanes[i*LANE_W +: LANE_W];
    end
  end

endmodule

// File: rtl/dbcfg_tile.sv
module dbcfg_tile #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int TILE_W     = 16,
  parameter int FEAT_W     = 8,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 4,
  parameter int VAL_W      = 8,
  parameter int NUM_IN     = 4,
  parameter int LANE_W     = 16,
  parameter int FEATURE_ID = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TILE_W-1:0]        tile_id,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     cfg_write,
  input  logic                     cfg_read,
  input  logic                     shadow_sel,
  input  logic                     shadow_live,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_IN*LANE_W-1:0] route_in,
  output logic [LANE_W-1:0]        route_out
);

  import dbcfg_pkg::*;

  localparam int IDX_W = idx_width(NUM_REGS);

  logic             sel_hit;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] bank_rval [NUM_BANKS];
  logic [VAL_W-1:0] bank_sel0 [NUM_BANKS];
  logic [VAL_W-1:0] live_sel;
  logic [VAL_W-1:0] rd_val;
  logic             wr_ok;
  bank_e            acc_bank;
  logic [DATA_W-1:0] rdata_q;

  dbcfg_addr_decode #(
    .ADDR_W(ADDR_W), .TILE_W(TILE_W), .FEAT_W(FEAT_W), .REG_W(REG_W),
    .NUM_REGS(NUM_REGS), .FEATURE_ID(FEATURE_ID)
  ) u_dec (
    .addr(cfg_addr), .tile_id(tile_id),
    .sel_hit(sel_hit), .in_range(in_range), .idx(idx)
  );

  assign acc_bank = bank_e'(shadow_sel);
  assign wr_ok    = cfg_write && sel_hit && in_range;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbcfg_bank #(.NUM_REGS(NUM_REGS), .VAL_W(VAL_W)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_ok && (acc_bank == bank_e'(b))),
      .widx(idx), .wval(cfg_wdata[VAL_W-1:0]),
      .ridx(idx), .rval(bank_rval[b]), .sel0(bank_sel0[b])
    );
  end

  assign rd_val   = in_range ? bank_rval[acc_bank] : '0;
  assign live_sel = shadow_live ? bank_sel0[BANK_SHADOW] : bank_sel0[BANK_PRIMARY];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cfg_read && sel_hit) begin
      rdata_q <= DATA_W'(rd_val);
    end
  end

  assign rdata = rdata_q;

  dbcfg_route_mux #(.NUM_IN(NUM_IN), .LANE_W(LANE_W), .SEL_W(VAL_W)) u_mux (
    .lanes(route_in), .sel(live_sel), .out(route_out)
  );

endmodule

// File: rtl/dbcfg_tile_chk.sv
module dbcfg_tile_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TILE_W = 16,
  parameter int VAL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [TILE_W-1:0] tile_id,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_write,
  input logic              cfg_read,
  input logic              shadow_sel,
  input logic [DATA_W-1:0] rdata,
  input logic [VAL_W-1:0]  prim_sel0,
  input logic [VAL_W-1:0]  shad_sel0
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (rdata == '0 && prim_sel0 == '0 && shad_sel0 == '0));

  p_primary_write_keeps_shadow_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_write && !shadow_sel) |=> $stable(shad_sel0));

  p_shadow_write_keeps_primary_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_write && shadow_sel) |=> $stable(prim_sel0));

  p_idle_read_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_read |=> $stable(rdata));

  p_foreign_tile_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr[TILE_W-1:0] != tile_id) |=>
      ($stable(prim_sel0) && $stable(shad_sel0) && $stable(rdata)));

endmodule

bind dbcfg_tile dbcfg_tile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TILE_W(TILE_W), .VAL_W(VAL_W)
) u_chk (
  .clk(clk), .rst(rst), .tile_id(tile_id), .cfg_addr(cfg_addr),
  .cfg_write(cfg_write), .cfg_read(cfg_read), .shadow_sel(shadow_sel),
  .rdata(rdata), .prim_sel0(bank_sel0[0]), .shad_sel0(bank_sel0[1])
);

// File: tb/dbcfg_tile_bench.sv
module dbcfg_tile_bench;

  localparam int NUM_IN = 4;
  localparam int LANE_W = 16;
  localparam logic [15:0] TILE = 16'h0042;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tile_id = TILE;
  logic [31:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_write = 1'b0;
  logic        cfg_read = 1'b0;
  logic        shadow_sel = 1'b0;
  logic        shadow_live = 1'b0;
  logic [31:0] rdata;
  logic [NUM_IN*LANE_W-1:0] route_in;
  logic [15:0] route_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  dbcfg_tile u_dbcfg_tile (
    .clk(clk), .rst(rst), .tile_id(tile_id), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_write(cfg_write), .cfg_read(cfg_read),
    .shadow_sel(shadow_sel), .shadow_live(shadow_live), .rdata(rdata),
    .route_in(route_in), .route_out(route_out)
  );

  function automatic logic [15:0] lane(input int i);
    return 16'hA000 + 16'(i * 16'h0111);
  endfunction

  initial begin
    for (int i = 0; i < NUM_IN; i++) route_in[i*LANE_W +: LANE_W] = lane(i);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 write, 1 read and compare rdata, 2 set shadow_live and compare route_out
  typedef struct packed {
    logic [1:0]  op;
    logic        db;
    logic        live;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 32'h00050042, 32'h00000002, 32'h0,        8'd2}, // R2
    '{2'd1, 1'b0, 1'b0, 32'h00050042, 32'h0,        32'h00000002, 8'd2}, // R2
    '{2'd2, 1'b0, 1'b0, 32'h0,        32'h0,        32'h0000A222, 8'd4}, // R4
    '{2'd0, 1'b1, 1'b0, 32'h00050042, 32'h00000001, 32'h0,        8'd3}, // R3
    '{2'd2, 1'b0, 1'b0, 32'h0,        32'h0,        32'h0000A222, 8'd4}, // R4
    '{2'd1, 1'b1, 1'b0, 32'h00050042, 32'h0,        32'h00000001, 8'd3}, // R3
    '{2'd1, 1'b0, 1'b0, 32'h00050042, 32'h0,        32'h00000002, 8'd3}, // R3
    '{2'd2, 1'b0, 1'b1, 32'h0,        32'h0,        32'h0000A111, 8'd5}, // R5
    '{2'd2, 1'b0, 1'b0, 32'h0,        32'h0,        32'h0000A222, 8'd5}, // R5
    '{2'd0, 1'b0, 1'b0, 32'h03050042, 32'h0000007E, 32'h0,        8'd6}, // R6
    '{2'd1, 1'b0, 1'b0, 32'h03050042, 32'h0,        32'h0000007E, 8'd6}, // R6
    '{2'd0, 1'b0, 1'b0, 32'h01050043, 32'h00000033, 32'h0,        8'd7}, // R7
    '{2'd1, 1'b0, 1'b0, 32'h01050042, 32'h0,        32'h00000000, 8'd7}, // R7
    '{2'd0, 1'b0, 1'b0, 32'h02060042, 32'h00000044, 32'h0,        8'd8}, // R8
    '{2'd1, 1'b0, 1'b0, 32'h02050042, 32'h0,        32'h00000000, 8'd8}, // R8
    '{2'd0, 1'b0, 1'b0, 32'h04050042, 32'h00000055, 32'h0,        8'd8}, // R8
    '{2'd1, 1'b0, 1'b0, 32'h04050042, 32'h0,        32'h00000000, 8'd8}, // R8
    '{2'd0, 1'b0, 1'b0, 32'h01050042, 32'h000001FF, 32'h0,        8'd2}, // R2
    '{2'd1, 1'b0, 1'b0, 32'h01050042, 32'h0,        32'h000000FF, 8'd2}, // R2
    '{2'd1, 1'b0, 1'b0, 32'h01050099, 32'h0,        32'h000000FF, 8'd6}, // R6
    '{2'd0, 1'b1, 1'b0, 32'h00050042, 32'h00000006, 32'h0,        8'd9}  // R9
  };

  task automatic do_write(input logic db, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    shadow_sel = db; cfg_addr = a; cfg_wdata = d; cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
  endtask

  task automatic do_read(input logic db, input logic [31:0] a);
    @(negedge clk);
    shadow_sel = db; cfg_addr = a; cfg_read = 1'b1;
    @(negedge clk);
    cfg_read = 1'b0;
  endtask

  task automatic set_live(input logic live);
    @(negedge clk);
    shadow_live = live;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 route primary", {16'h0, route_out}, {16'h0, lane(0)});
    set_live(1'b1);
    check("R1 route shadow", {16'h0, route_out}, {16'h0, lane(0)});
    set_live(1'b0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[v].req, v);
      case (VEC[v].op)
        2'd0: do_write(VEC[v].db, VEC[v].addr, VEC[v].data);
        2'd1: begin
          do_read(VEC[v].db, VEC[v].addr);
          check(tag, rdata, VEC[v].exp);
        end
        default: begin
          set_live(VEC[v].live);
          check(tag, {16'h0, route_out}, VEC[v].exp);
        end
      endcase
    end

    // R9 select beyond last lane, then back in range
    set_live(1'b1);
    check("R9 out of range select", {16'h0, route_out}, 32'h0);
    do_write(1'b1, 32'h00050042, 32'h00000003);
    #1;
    check("R9 lane 3", {16'h0, route_out}, {16'h0, lane(3)});
    set_live(1'b0);
    check("R4 primary lane 2", {16'h0, route_out}, {16'h0, lane(2)});

    // R1 reset mid-run clears both copies
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 primary route after reset", {16'h0, route_out}, {16'h0, lane(0)});
    do_read(1'b1, 32'h03050042);
    check("R1 shadow reg after reset", rdata, 32'h0);
    do_read(1'b0, 32'h03050042);
    check("R1 primary reg after reset", rdata, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule